// File: doc/BRIEF.md
# Jitter Attenuator Elastic Bit Buffer

This block is a one-bit-wide elastic store that sits between a jittery write clock and a smoothed read clock. Serial bits are captured on the write clock and replayed in order on the read clock. A fill count, kept in the read domain, gives the clock smoother a view of the buffer's occupancy. With limit mode on, the block raises a speed-up or slow-down request so that the smoother can keep the buffer one bit away from its edges.

A write into a full buffer is dropped and recorded as an overflow. A read from an empty buffer is refused and recorded as an underrun. Each event sets a sticky flag. The flag stays set until a write-one-to-clear strobe removes it. Two enable bits decide which flags drive the shared interrupt line. A centering strobe moves the read pointer so that occupancy returns to half depth. A bypass control sends the input bit straight to the output and leaves the store untouched.

Pointers are ring counters over twice the depth. They cross between the clock domains as Gray codes. After reset the store holds half its depth of zero bits.

Top module: `jaElasticFifo`

## Requirements
- R1: After reset, `fill` reads DEPTH/2 (24), all flags, requests and `irq` are low, `dataOut` is 0, and the 24 preloaded bits read back as 0.
- R2: Bits leave the buffer in the order they were written. Once both domains are idle, `fill` equals 24 plus the accepted writes minus the accepted reads.
- R3: A write while the fill is 48 is discarded, leaves `fill` at 48, and sets `ovrFlag`. `fill` never exceeds 48.
- R4: A read while the fill is 0 sets `undFlag`, does not move the read pointer, and leaves `dataOut` at the last bit read.
- R5: `ovrFlag` and `undFlag` stay set until a one on `clrOvr` or `clrUnd`, respectively. A new event in the same cycle as its clear leaves the flag set.
- R6: `irq` is high exactly when (`ovrFlag` and `ovrIntEn`) or (`undFlag` and `undIntEn`).
- R7: With `limitEn` high, `speedUp` is 1 when the fill is 47 or 48, and `slowDown` is 1 when the fill is 0 or 1. With `limitEn` low, both are 0.
- R8: A one-cycle pulse on `center` sets the read pointer so that `fill` becomes 24.
- R9: While `bypass` is high, `dataOut` equals `dataIn` combinationally, and `wrEn`, `rdEn` and `center` have no effect on the stored bits or the fill.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wrClk | input | 1 | Jittery write clock |
| rdClk | input | 1 | Smoothed read clock |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| wrEn | input | 1 | Write strobe (write domain) |
| dataIn | input | 1 | Serial input bit |
| rdEn | input | 1 | Read strobe (read domain) |
| bypass | input | 1 | Route dataIn straight to dataOut |
| center | input | 1 | Re-center pulse (read domain) |
| limitEn | input | 1 | Enable speed-up/slow-down requests |
| clrOvr | input | 1 | Write-one-to-clear for ovrFlag |
| clrUnd | input | 1 | Write-one-to-clear for undFlag |
| ovrIntEn | input | 1 | Overflow interrupt enable |
| undIntEn | input | 1 | Underrun interrupt enable |
| dataOut | output | 1 | Serial output bit |
| fill | output | 6 | Occupancy seen from the read domain |
| speedUp | output | 1 | Request a faster read clock |
| slowDown | output | 1 | Request a slower read clock |
| ovrFlag | output | 1 | Sticky overflow status |
| undFlag | output | 1 | Sticky underrun status |
| irq | output | 1 | Masked interrupt |

## Verification
The bench fills the buffer to every level from 1 to 48 and checks the count and both limit requests at each level. It then drains the buffer and compares every bit. This catches an off-by-one in the ring arithmetic or the Gray decode, which would show up as a wrong count or a shifted bit stream near the wrap point. It pushes three writes past full and one read past empty. A design that let the extra writes in would corrupt the replayed stream. A design that moved the pointer on an empty read would return a stale bit in place of the held last bit. It also tests a clear that arrives together with a new underrun, centering from both above and below half, and a bypass burst of strobes that must leave the stored bits intact.

// File: rtl/jaFifoPkg.sv
package jaFifoPkg;
  // strobes from the read-side control into the datapath
  typedef struct packed {
    logic doRead;
    logic doCenter;
  } rdStrobe_t;
endpackage

// File: rtl/jaFifoData.sv
module jaFifoData
  import jaFifoPkg::*;
#(
  parameter int DEPTH = 48,
  parameter int PTR_W = $clog2(2 * DEPTH)
) (
  input  logic             wrClk,
  input  logic             rdClk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             dataIn,
  input  logic             bypass,
  input  rdStrobe_t        strobe,
  input  logic [PTR_W-1:0] centerIdx,
  output logic [PTR_W-1:0] rdIdx,
  output logic [PTR_W-1:0] wrGray,
  output logic             ovfToggle,
  output logic             bufOut
);
  localparam int RING   = 2 * DEPTH;
  localparam int OFF    = ((1 << PTR_W) - RING) / 2;
  localparam int HALF   = DEPTH / 2;
  localparam int ADDR_W = $clog2(DEPTH);
  typedef logic [PTR_W-1:0] ptr_t;

  function automatic ptr_t ringInc(ptr_t x);
    return (x == ptr_t'(RING - 1)) ? '0 : x + 1'b1;
  endfunction
  function automatic ptr_t ringSub(ptr_t a, ptr_t b);
    logic [PTR_W:0] t;
    if (a >= b) t = {1'b0, a} - {1'b0, b};
    else        t = {1'b0, a} + (PTR_W+1)'(RING) - {1'b0, b};
    return t[PTR_W-1:0];
  endfunction
  // offset into the symmetric window so the wrap changes one bit
  function automatic ptr_t toGray(ptr_t i);
    ptr_t b;
    b = i + ptr_t'(OFF);
    return b ^ (b >> 1);
  endfunction
  function automatic ptr_t fromGray(ptr_t g);
    ptr_t b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int k = PTR_W - 2; k >= 0; k--) b[k] = b[k+1] ^ g[k];
    return b - ptr_t'(OFF);
  endfunction
  function automatic logic [ADDR_W-1:0] toAddr(ptr_t i);
    return (i >= ptr_t'(DEPTH)) ? ADDR_W'(i - ptr_t'(DEPTH)) : ADDR_W'(i);
  endfunction

  logic [DEPTH-1:0] store;
  ptr_t wrIdx, rdGray, rdSync1, rdSync2, rdSyncIdx, wrFill;
  logic isFull, doWrite, overflow;

  // write domain
  assign rdSyncIdx = fromGray(rdSync2);
  assign wrFill    = ringSub(wrIdx, rdSyncIdx);
  assign isFull    = (wrFill >= ptr_t'(DEPTH));
  assign doWrite   = wrEn & ~bypass & ~isFull;
  assign overflow  = wrEn & ~bypass & isFull;

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrIdx     <= ptr_t'(HALF);
      wrGray    <= toGray(ptr_t'(HALF));
      rdSync1   <= toGray('0);
      rdSync2   <= toGray('0);
      ovfToggle <= 1'b0;
    end else begin
      rdSync1 <= rdGray;
      rdSync2 <= rdSync1;
      wrGray  <= toGray(wrIdx);
      if (doWrite) wrIdx <= ringInc(wrIdx);
      if (overflow) ovfToggle <= ~ovfToggle;
    end
  end

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) store <= '0;
    else if (doWrite) store[toAddr(wrIdx)] <= dataIn;
  end

  // read domain
  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdIdx  <= '0;
      rdGray <= toGray('0);
      bufOut <= 1'b0;
    end else begin
      rdGray <= toGray(rdIdx);
      if (strobe.doCenter) rdIdx <= centerIdx;
      else if (strobe.doRead) begin
        rdIdx  <= ringInc(rdIdx);
        bufOut <= store[toAddr(rdIdx)];
      end
    end
  end

  AST_WR_BOUND: assert property (@(posedge wrClk) disable iff (!rstN)
    wrFill <= ptr_t'(DEPTH)); // R3
endmodule

// File: rtl/jaFifoCtl.sv
module jaFifoCtl
  import jaFifoPkg::*;
#(
  parameter int DEPTH  = 48,
  parameter int PTR_W  = $clog2(2 * DEPTH),
  parameter int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              rdEn,
  input  logic              center,
  input  logic              bypass,
  input  logic              limitEn,
  input  logic              clrOvr,
  input  logic              clrUnd,
  input  logic              ovrIntEn,
  input  logic              undIntEn,
  input  logic [PTR_W-1:0]  wrGray,
  input  logic [PTR_W-1:0]  rdIdx,
  input  logic              ovfToggle,
  output rdStrobe_t         strobe,
  output logic [PTR_W-1:0]  centerIdx,
  output logic [FILL_W-1:0] fill,
  output logic              speedUp,
  output logic              slowDown,
  output logic              ovrFlag,
  output logic              undFlag,
  output logic              irq
);
  localparam int RING = 2 * DEPTH;
  localparam int OFF  = ((1 << PTR_W) - RING) / 2;
  localparam int HALF = DEPTH / 2;
  typedef logic [PTR_W-1:0] ptr_t;

  function automatic ptr_t ringSub(ptr_t a, ptr_t b);
    logic [PTR_W:0] t;
    if (a >= b) t = {1'b0, a} - {1'b0, b};
    else        t = {1'b0, a} + (PTR_W+1)'(RING) - {1'b0, b};
    return t[PTR_W-1:0];
  endfunction
  function automatic ptr_t toGray(ptr_t i);
    ptr_t b;
    b = i + ptr_t'(OFF);
    return b ^ (b >> 1);
  endfunction
  function automatic ptr_t fromGray(ptr_t g);
    ptr_t b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int k = PTR_W - 2; k >= 0; k--) b[k] = b[k+1] ^ g[k];
    return b - ptr_t'(OFF);
  endfunction

  ptr_t wrSync1, wrSync2, wrSyncIdx, fillRing;
  logic [2:0] ovfSync;
  logic ovfPulse, isEmpty, underrun;

  assign wrSyncIdx = fromGray(wrSync2);
  assign fillRing  = ringSub(wrSyncIdx, rdIdx);
  assign isEmpty   = (fillRing == '0);
  assign ovfPulse  = ovfSync[2] ^ ovfSync[1];
  assign centerIdx = ringSub(wrSyncIdx, ptr_t'(HALF));

  always_comb begin
    strobe.doCenter = center & ~bypass;
    strobe.doRead   = rdEn & ~bypass & ~center & ~isEmpty;
  end
  assign underrun = rdEn & ~bypass & ~center & isEmpty;

  assign fill     = FILL_W'(fillRing);
  assign speedUp  = limitEn & (fillRing >= ptr_t'(DEPTH - 1));
  assign slowDown = limitEn & (fillRing <= ptr_t'(1));
  assign irq      = (ovrFlag & ovrIntEn) | (undFlag & undIntEn);

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      wrSync1 <= toGray(ptr_t'(HALF));
      wrSync2 <= toGray(ptr_t'(HALF));
      ovfSync <= '0;
      ovrFlag <= 1'b0;
      undFlag <= 1'b0;
    end else begin
      wrSync1 <= wrGray;
      wrSync2 <= wrSync1;
      ovfSync <= {ovfSync[1:0], ovfToggle};
      // a new event outranks a clear in the same cycle
      if (ovfPulse) ovrFlag <= 1'b1;
      else if (clrOvr) ovrFlag <= 1'b0;
      if (underrun) undFlag <= 1'b1;
      else if (clrUnd) undFlag <= 1'b0;
    end
  end

  AST_FILL_MAX: assert property (@(posedge rdClk) disable iff (!rstN)
    fillRing <= ptr_t'(DEPTH)); // R3
  AST_UND_SET: assert property (@(posedge rdClk) disable iff (!rstN)
    (rdEn && !bypass && !center && fill == '0) |=> undFlag); // R4
  AST_EMPTY_HOLD: assert property (@(posedge rdClk) disable iff (!rstN)
    (fill == '0 && !center) |=> $stable(rdIdx)); // R4
  AST_OVR_STICKY: assert property (@(posedge rdClk) disable iff (!rstN)
    (ovrFlag && !clrOvr) |=> ovrFlag); // R5
  AST_IRQ_SRC: assert property (@(posedge rdClk) disable iff (!rstN)
    irq |-> (ovrFlag || undFlag)); // R6
  AST_BYPASS_FREEZE: assert property (@(posedge rdClk) disable iff (!rstN)
    bypass |=> $stable(rdIdx)); // R9
endmodule

// File: rtl/jaElasticFifo.sv
module jaElasticFifo
  import jaFifoPkg::*;
#(
  parameter int DEPTH  = 48,
  parameter int PTR_W  = $clog2(2 * DEPTH),
  parameter int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              dataIn,
  input  logic              rdEn,
  input  logic              bypass,
  input  logic              center,
  input  logic              limitEn,
  input  logic              clrOvr,
  input  logic              clrUnd,
  input  logic              ovrIntEn,
  input  logic              undIntEn,
  output logic              dataOut,
  output logic [FILL_W-1:0] fill,
  output logic              speedUp,
  output logic              slowDown,
  output logic              ovrFlag,
  output logic              undFlag,
  output logic              irq
);
  rdStrobe_t        strobe;
  logic [PTR_W-1:0] centerIdx, rdIdx, wrGray;
  logic             ovfToggle, bufOut;

  jaFifoData #(.DEPTH(DEPTH), .PTR_W(PTR_W)) uData (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .wrEn(wrEn), .dataIn(dataIn),
    .bypass(bypass), .strobe(strobe), .centerIdx(centerIdx), .rdIdx(rdIdx),
    .wrGray(wrGray), .ovfToggle(ovfToggle), .bufOut(bufOut)
  );

  jaFifoCtl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .FILL_W(FILL_W)) uCtl (
    .rdClk(rdClk), .rstN(rstN), .rdEn(rdEn), .center(center), .bypass(bypass),
    .limitEn(limitEn), .clrOvr(clrOvr), .clrUnd(clrUnd), .ovrIntEn(ovrIntEn),
    .undIntEn(undIntEn), .wrGray(wrGray), .rdIdx(rdIdx), .ovfToggle(ovfToggle),
    .strobe(strobe), .centerIdx(centerIdx), .fill(fill), .speedUp(speedUp),
    .slowDown(slowDown), .ovrFlag(ovrFlag), .undFlag(undFlag), .irq(irq)
  );

  assign dataOut = bypass ? dataIn : bufOut;
endmodule

// File: tb/sim_jaElasticFifo.sv
`timescale 1ns/1ps
module sim_jaElasticFifo;
  localparam int DEPTH = 48;
  localparam int HALF  = DEPTH / 2;

  logic wrClk = 0, rdClk = 0, rstN = 0;
  logic wrEn = 0, dataIn = 0, rdEn = 0, bypass = 0, center = 0, limitEn = 1;
  logic clrOvr = 0, clrUnd = 0, ovrIntEn = 0, undIntEn = 0;
  logic dataOut, speedUp, slowDown, ovrFlag, undFlag, irq;
  logic [5:0] fill;

  int vectors = 0, errors = 0;
  bit model[$];
  bit lastBit = 0;

  always #2 rdClk = ~rdClk;   // 250 MHz read clock
  always #3 wrClk = ~wrClk;   // unrelated write clock

  jaElasticFifo u0 (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .wrEn(wrEn), .dataIn(dataIn),
    .rdEn(rdEn), .bypass(bypass), .center(center), .limitEn(limitEn),
    .clrOvr(clrOvr), .clrUnd(clrUnd), .ovrIntEn(ovrIntEn), .undIntEn(undIntEn),
    .dataOut(dataOut), .fill(fill), .speedUp(speedUp), .slowDown(slowDown),
    .ovrFlag(ovrFlag), .undFlag(undFlag), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit pat(input int i);
    return ^(i * 13 + 5 + (i >> 2));
  endfunction

  task automatic wrBit(input bit b);
    @(negedge wrClk); wrEn = 1; dataIn = b;
    @(negedge wrClk); wrEn = 0;
    if (!bypass && model.size() < DEPTH) model.push_back(b);
  endtask

  task automatic rdBit(output bit b);
    @(negedge rdClk); rdEn = 1;
    @(negedge rdClk); rdEn = 0;
    b = dataOut;
  endtask

  task automatic settle();
    repeat (12) @(negedge wrClk);
    @(negedge rdClk);
  endtask

  task automatic rdPulse(ref logic s);
    @(negedge rdClk); s = 1;
    @(negedge rdClk); s = 0;
  endtask

  task automatic drainCompare(input string req);
    bit got;
    while (model.size() > 0) begin
      rdBit(got);
      check(req, got, model[0]);
      lastBit = model.pop_front();
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    bit got;
    repeat (5) @(negedge rdClk);
    rstN = 1;
    @(negedge rdClk);
    // R1 reset state
    check("R1 fill", fill, HALF);
    check("R1 ovrFlag", ovrFlag, 0);
    check("R1 undFlag", undFlag, 0);
    check("R1 irq", irq, 0);
    check("R1 speedUp", speedUp, 0);
    check("R1 slowDown", slowDown, 0);
    check("R1 dataOut", dataOut, 0);
    for (int i = 0; i < HALF; i++) model.push_back(1'b0);
    drainCompare("R1 preload");
    settle();
    check("R1 drained fill", fill, 0);
    check("R7 slowDown at 0", slowDown, 1);

    // R2/R7 sweep over every fill level
    for (int n = 1; n <= DEPTH; n++) begin
      for (int i = 0; i < n; i++) wrBit(pat(i + n));
      settle();
      check("R2 fill level", fill, n);
      check("R7 speedUp", speedUp, (n >= DEPTH - 1) ? 1 : 0);
      check("R7 slowDown", slowDown, (n <= 1) ? 1 : 0);
      if (n == DEPTH - 1) begin
        limitEn = 0; #1;
        check("R7 limit off", speedUp | slowDown, 0);
        limitEn = 1;
      end
      drainCompare("R2 order");
      settle();
      check("R2 empty", fill, 0);
    end

    // R3 overflow
    for (int i = 0; i < DEPTH; i++) wrBit(pat(3 * i));
    for (int i = 0; i < 3; i++) wrBit(~pat(3 * i + 100));
    settle();
    check("R3 fill stays full", fill, DEPTH);
    check("R3 ovrFlag", ovrFlag, 1);
    check("R6 irq masked", irq, 0);
    ovrIntEn = 1; #1;
    check("R6 irq ovr", irq, 1);
    drainCompare("R3 dropped writes");
    settle();

    // R4 underrun
    rdBit(got);
    check("R4 dataOut held", got, lastBit);
    settle();
    check("R4 undFlag", undFlag, 1);
    check("R4 fill", fill, 0);
    check("R4 slowDown", slowDown, 1);

    // R5 clears, R6 masking
    rdPulse(clrOvr);
    check("R5 ovr cleared", ovrFlag, 0);
    check("R5 und kept", undFlag, 1);
    check("R6 irq none", irq, 0);
    undIntEn = 1; #1;
    check("R6 irq und", irq, 1);
    @(negedge rdClk); clrUnd = 1; rdEn = 1;
    @(negedge rdClk); clrUnd = 0; rdEn = 0;
    check("R5 set wins", undFlag, 1);
    rdPulse(clrUnd);
    check("R5 und cleared", undFlag, 0);
    check("R6 irq off", irq, 0);

    // R8 centering from below and above half
    for (int i = 0; i < 5; i++) wrBit(1'b1);
    settle();
    check("R8 pre fill", fill, 5);
    rdPulse(center);
    settle();
    check("R8 center up", fill, HALF);
    for (int i = 0; i < 10; i++) begin
      @(negedge wrClk); wrEn = 1;
      @(negedge wrClk); wrEn = 0;
    end
    settle();
    check("R8 pre fill high", fill, HALF + 10);
    rdPulse(center);
    settle();
    check("R8 center down", fill, HALF);
    for (int i = 0; i < HALF; i++) rdBit(got);
    model.delete();
    settle();
    check("R8 drained", fill, 0);

    // R9 bypass
    for (int i = 0; i < 3; i++) wrBit(pat(i + 200));
    settle();
    bypass = 1;
    for (int v = 0; v < 4; v++) begin
      dataIn = v[0]; #1;
      check("R9 passthrough", dataOut, v[0]);
    end
    for (int i = 0; i < 4; i++) wrBit(1'b1);
    for (int i = 0; i < 4; i++) rdBit(got);
    rdPulse(center);
    bypass = 0;
    settle();
    check("R9 fill untouched", fill, 3);
    check("R9 no underrun", undFlag, 0);
    drainCompare("R9 data untouched");

    finishRun();
  end
endmodule